// File: doc/BRIEF.md
# Periodic Down-Count Tick Timer

This block produces a steady periodic event for an operating-system scheduler or any other software that needs a regular time base. A 24-bit counter counts down from a software-loaded reload value. When it reaches zero it sets a sticky count flag and, if tick interrupts are enabled, pulses an interrupt request for one clock. On the next count tick it reloads and starts the next period. A reload value of N-1 therefore gives a period of N count ticks.

Counting runs either on every bus clock or only on cycles where an external clock-enable input is high. That input is expected to pulse once every eight bus clocks. Software reaches the block through a single-cycle synchronous register port with three registers: control/status, reload and current value. Any write to the current-value register zeroes the counter. The asynchronous active-low reset is released through an internal synchronizer.

Top module: `tick_timer`

## Requirements
- R1: The reload and current-value registers are 24 bits wide. Writes keep only `wdata[23:0]`, and reads return zeros in bits 31:24.
- R2: With the full-rate source selected (control bit 2 = 1) and reload value R > 0, successive interrupt pulses are exactly R+1 bus clocks apart.
- R3: With control bit 2 = 0, the counter advances only on cycles where `slow_en` is high. With `slow_en` high one cycle in eight, interrupts are (R+1)*8 bus clocks apart.
- R4: A write of any data to the current-value register sets the counter to zero and clears the count flag.
- R5: While control bit 0 is 0, the counter holds its value.
- R6: `irq` pulses high for exactly one clock on each wrap to zero, and only when control bit 1 is 1. With bit 1 clear, `irq` stays low while the counter still wraps.
- R7: Control bit 16 is a read-only count flag. A wrap sets it. A read of the control register returns its current value and then clears it. A write of the control register leaves it unchanged.
- R8: A count tick at a non-zero value decrements the counter by one. A count tick at zero loads the reload value, so a counter started from zero reads 0, then R, then R-1 on consecutive ticks.
- R9: With a reload value of 0 and the counter at 0, the counter stays at 0, the flag is not set and `irq` stays low.
- R10: After reset, every register reads zero and `irq` is low.
- R11: The register offsets on `addr` are 0 for control/status, 1 for reload, 2 for current value, and 3 reads as zero. `rdata` is registered: it shows the addressed register the clock after a cycle with `rd_en` high, and it holds otherwise. The control register reads enable, interrupt enable and source in bits 0, 1 and 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronously released inside |
| slow_en | input | 1 | Clock enable for the divided count source, one pulse per eight clocks |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| rd_en | input | 1 | Register read strobe, one cycle per read |
| addr | input | 2 | Register offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | One-cycle tick interrupt request |

## Verification
The checker takes `wr_en` and `rd_en` to be one-cycle strobes with a valid offset. It takes `slow_en` to be a clean synchronous level. No assertion depends on the spacing of `slow_en`, so the counting and reload properties hold for any enable pattern. The bench changes every input only on the falling clock edge and keeps each strobe high for one cycle. It drives `slow_en` from a free-running modulo-eight count, so the divided-source periods the bench expects are exact multiples of eight.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_INT_BIT  = 1;
  localparam int CTRL_SRC_BIT  = 2;
  localparam int CTRL_FLAG_BIT = 16;
  localparam int ADDR_W        = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CTRL    = 2'd0,
    SEL_RELOAD  = 2'd1,
    SEL_CURRENT = 2'd2,
    SEL_NONE    = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic src_fast;
    logic int_en;
    logic cnt_en;
  } ctrl_t;
endpackage

// File: rtl/tick_rst_sync.sv
module tick_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/tick_regs.sv
module tick_regs
  import tick_timer_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              flag,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  reload,
  output logic              cur_wr,
  output logic              ctrl_rd,
  output logic [DATA_W-1:0] rdata
);
  reg_sel_e          sel;
  ctrl_t             ctrl_d;
  logic [CNT_W-1:0]  reload_d;
  logic [DATA_W-1:0] rdata_d;
  logic              ctrl_we;
  logic              reload_we;
  logic              unused_wdata;

  assign sel          = reg_sel_e'(addr);
  assign ctrl_we      = wr_en && (sel == SEL_CTRL);
  assign reload_we    = wr_en && (sel == SEL_RELOAD);
  assign cur_wr       = wr_en && (sel == SEL_CURRENT);
  assign ctrl_rd      = rd_en && (sel == SEL_CTRL);
  assign unused_wdata = ^wdata;

  always_comb begin
    ctrl_d   = ctrl;
    reload_d = reload;
    if (ctrl_we) begin
      ctrl_d.cnt_en   = wdata[CTRL_EN_BIT];
      ctrl_d.int_en   = wdata[CTRL_INT_BIT];
      ctrl_d.src_fast = wdata[CTRL_SRC_BIT];
    end
    if (reload_we) reload_d = wdata[CNT_W-1:0];
  end

  always_comb begin
    rdata_d = rdata;
    if (rd_en) begin
      rdata_d = '0;
      unique case (sel)
        SEL_CTRL: begin
          rdata_d[CTRL_EN_BIT]   = ctrl.cnt_en;
          rdata_d[CTRL_INT_BIT]  = ctrl.int_en;
          rdata_d[CTRL_SRC_BIT]  = ctrl.src_fast;
          rdata_d[CTRL_FLAG_BIT] = flag;
        end
        SEL_RELOAD:  rdata_d = DATA_W'(reload);
        SEL_CURRENT: rdata_d = DATA_W'(cnt);
        SEL_NONE:    rdata_d = '0;
        default:     rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      reload <= '0;
      rdata  <= '0;
    end else begin
      ctrl   <= ctrl_d;
      reload <= reload_d;
      rdata  <= rdata_d;
    end
  end
endmodule

// File: rtl/tick_src_sel.sv
module tick_src_sel (
  input  logic cnt_en,
  input  logic src_fast,
  input  logic slow_en,
  output logic tick
);
  logic src_pulse;

  always_comb begin
    src_pulse = src_fast ? 1'b1 : slow_en;
    tick      = cnt_en && src_pulse;
  end
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cur_wr,
  input  logic             ctrl_rd,
  input  logic             int_en,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt,
  output logic             flag,
  output logic             irq
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_d;
  logic             flag_d;
  logic             irq_d;
  logic             wrap;

  assign wrap = tick && !cur_wr && (cnt == ONE);

  always_comb begin
    cnt_d = cnt;
    if (cur_wr)           cnt_d = '0;
    else if (tick) begin
      if (cnt == '0)      cnt_d = reload;
      else                cnt_d = cnt - ONE;
    end
  end

  always_comb begin
    flag_d = flag;
    if (wrap)                    flag_d = 1'b1;
    else if (cur_wr || ctrl_rd)  flag_d = 1'b0;
    irq_d = wrap && int_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      cnt  <= cnt_d;
      flag <= flag_d;
      irq  <= irq_d;
    end
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic             rst_n_sync;
  ctrl_t            ctrl_q;
  logic             cnt_en;
  logic             int_en;
  logic             src_fast;
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] cnt;
  logic             flag;
  logic             cur_wr;
  logic             ctrl_rd;
  logic             tick;

  assign cnt_en   = ctrl_q.cnt_en;
  assign int_en   = ctrl_q.int_en;
  assign src_fast = ctrl_q.src_fast;

  tick_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  tick_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .cnt     (cnt),
    .flag    (flag),
    .ctrl    (ctrl_q),
    .reload  (reload),
    .cur_wr  (cur_wr),
    .ctrl_rd (ctrl_rd),
    .rdata   (rdata)
  );

  tick_src_sel u_src_sel (
    .cnt_en   (cnt_en),
    .src_fast (src_fast),
    .slow_en  (slow_en),
    .tick     (tick)
  );

  tick_counter #(.CNT_W(CNT_W)) u_counter (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .tick    (tick),
    .cur_wr  (cur_wr),
    .ctrl_rd (ctrl_rd),
    .int_en  (int_en),
    .reload  (reload),
    .cnt     (cnt),
    .flag    (flag),
    .irq     (irq)
  );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             cur_wr,
  input logic             ctrl_rd,
  input logic             cnt_en,
  input logic             int_en,
  input logic [CNT_W-1:0] reload,
  input logic [CNT_W-1:0] cnt,
  input logic             flag,
  input logic             irq
);
  AST_TICK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> cnt_en); // R5

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !cur_wr) |=> $stable(cnt)); // R5

  AST_CUR_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cur_wr |=> (cnt == '0) && !flag); // R4

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cur_wr && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1))); // R8

  AST_RELOAD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cur_wr && cnt == '0) |=> (cnt == $past(reload))); // R8

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R6

  AST_IRQ_NEEDS_INTEN: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(int_en)); // R6

  AST_IRQ_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cnt == '0) && flag); // R7

  AST_ZERO_RELOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (reload == '0 && cnt == '0) |=> !irq && (cnt == '0)); // R9

  AST_FLAG_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd && !(tick && cnt == CNT_W'(1))) |=> !flag); // R7
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n_sync),
  .tick    (tick),
  .cur_wr  (cur_wr),
  .ctrl_rd (ctrl_rd),
  .cnt_en  (cnt_en),
  .int_en  (int_en),
  .reload  (reload),
  .cnt     (cnt),
  .flag    (flag),
  .irq     (irq)
);

// File: tb/tick_timer_bench.sv
module tick_timer_bench;
  localparam int NV = 6;
  localparam int VR [NV] = '{1, 2, 5, 9, 3, 1};
  localparam bit VF [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
  localparam int VP [NV] = '{2, 3, 6, 10, 32, 16};

  logic        clk;
  logic        rst_n;
  logic        slow_en;
  logic        wr_en;
  logic        rd_en;
  logic [1:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  tick_timer u_tick_timer (
    .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  initial begin
    clk = 1'b0;
    forever #2 clk = ~clk;
  end

  initial begin
    slow_en = 1'b0;
    for (int d = 0; ; d = (d + 1) % 8) begin
      @(negedge clk);
      slow_en = (d == 7);
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic run(input int n, output int pulses);
    pulses = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (irq) pulses++;
    end
  endtask

  task automatic measure(output int per, output logic nxt);
    int guard = 0;
    while (!irq && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
    nxt = irq;
    per = 1;
    while (!irq && per < 2000) begin
      @(negedge clk);
      per++;
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired before the end of the run");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    int pulses;
    int per;
    logic nxt;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: reset state
    chk("R10 irq", {31'b0, irq}, 32'h0);
    chk("R10 rdata", rdata, 32'h0);
    rd(2'd0, v); chk("R10 ctrl", v, 32'h0);
    rd(2'd1, v); chk("R10 reload", v, 32'h0);
    rd(2'd2, v); chk("R10 current", v, 32'h0);
    rd(2'd3, v); chk("R11 unused offset", v, 32'h0);

    // R1: 24-bit reload register
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, v); chk("R1 reload width", v, 32'h00FF_FFFF);

    // R8: start from zero reads 0, R, R-1
    wr(2'd0, 32'h4);
    wr(2'd1, 32'd5);
    wr(2'd2, 32'h0);
    wr(2'd0, 32'h5);
    rd(2'd2, v); chk("R8 first", v, 32'd0);
    rd(2'd2, v); chk("R8 reload", v, 32'd5);
    rd(2'd2, v); chk("R8 step", v, 32'd4);

    // R5: disabled counter holds
    wr(2'd0, 32'h4);
    rd(2'd2, v); chk("R5 hold a", v, 32'd2);
    run(5, pulses);
    rd(2'd2, v); chk("R5 hold b", v, 32'd2);

    // R4: any write to current value zeroes it
    wr(2'd2, 32'h00AB_CDEF);
    rd(2'd2, v); chk("R4 clear", v, 32'd0);

    // R6/R7: wraps without interrupt set the flag only
    rd(2'd0, v);
    wr(2'd0, 32'h5);
    run(20, pulses); chk("R6 no irq when disabled", pulses, 32'd0);
    wr(2'd0, 32'h4);
    rd(2'd0, v); chk("R7 flag set, kept by ctrl write", v & 32'h0001_0007, 32'h0001_0004);
    rd(2'd0, v); chk("R7 flag cleared by read", v & 32'h0001_0007, 32'h0000_0004);

    // R4: current-value write clears the flag
    wr(2'd0, 32'h5);
    run(20, pulses);
    wr(2'd0, 32'h4);
    wr(2'd2, 32'h1);
    rd(2'd0, v); chk("R4 flag cleared", v & 32'h0001_0000, 32'h0);

    // R9: reload of zero gives no wraps
    wr(2'd1, 32'h0);
    wr(2'd2, 32'h0);
    wr(2'd0, 32'h7);
    rd(2'd0, v); chk("R11 ctrl readback", v & 32'h7, 32'h7);
    run(40, pulses); chk("R9 no irq", pulses, 32'd0);
    rd(2'd2, v); chk("R9 counter stays zero", v, 32'd0);
    rd(2'd0, v); chk("R9 no flag", v & 32'h0001_0000, 32'h0);

    // R2/R3/R6: period table
    for (int i = 0; i < NV; i++) begin
      wr(2'd0, 32'h0);
      wr(2'd1, VR[i]);
      wr(2'd2, 32'h0);
      wr(2'd0, VF[i] ? 32'h7 : 32'h3);
      measure(per, nxt);
      if (VF[i]) chk("R2 period", per, VP[i]);
      else       chk("R3 period", per, VP[i]);
      chk("R6 single-cycle pulse", {31'b0, nxt}, 32'h0);
    end
    wr(2'd0, 32'h0);

    finish_run();
  end
endmodule